// File: doc/BRIEF.md
# Address Strap Pin Decoder

This block resolves the slave address of a two-wire bus port expander from two strap pins. Each strap pin can be wired to ground, to the supply, to the data line or to the clock line. Wiring to a bus line cannot be seen from a static level, so the decoder watches both straps next to the bus lines for the whole of every transmission on the bus, whichever device that transmission is meant for. When the transmission ends, it settles on a wiring for each strap. The address can therefore follow a change of wiring without a power cycle.

The two classifications give the four low bits of a 7-bit address whose upper three bits are fixed at binary 110, so the block answers at one of sixteen addresses from 0x60 to 0x6F. At reset each strap is judged only by its level. A strap on an idle bus line reads high at that point and counts as tied to the supply. The reset classification also sets, four ports at a time, the default output byte and the pullup enable mask. These two values then hold until the next reset. Bus-line and strap inputs are expected already synchronised, with START and STOP given as one-cycle strobes from the bus front end.

Top module: `addr_strap_decoder`

## Requirements
- R1: The address output is binary 110 in bits 6:4, then two bits from the upper strap in bits 3:2, then two bits from the lower strap in bits 1:0. It always lies in 0x60..0x6F.
- R2: The upper strap (ad2_i) maps to bits 3:2 as follows: clock-tied 00, data-tied 01, ground 10, supply 11.
- R3: The lower strap (ad0_i) maps to bits 1:0 as follows: ground 00, supply 01, clock-tied 10, data-tied 11.
- R4: A new classification takes effect in the cycle after a STOP strobe that closes an open transmission. The address does not change in the middle of a transmission, and a STOP strobe with no transmission open has no effect.
- R5: A strap that equals a bus line in every sampled cycle of the transmission is tied to that line, provided that line was seen low at least once. Sampled cycles run from the START strobe cycle through the STOP strobe cycle.
- R6: A strap that differs from both lines in at least one sampled cycle is classified by its level in the STOP cycle: high gives supply, low gives ground.
- R7: If neither bus line is seen low during a transmission, the previous classification of both straps is kept.
- R8: Reset classifies each strap by its level alone. A strap held high by an idle bus line therefore reads as supply.
- R9: Port default byte and pullup mask come from the reset classification. Bits 3:0 follow the lower strap and bits 7:4 the upper strap. A nibble is 1111 unless its strap is ground, which gives 0000. Neither value changes until the next reset.
- R10: A strap that qualifies as tied to both lines is classified as clock-tied.
- R11: A START strobe inside an open transmission (repeated START) discards all samples taken before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ad0_i | input | 1 | Lower strap pin, synchronised |
| ad2_i | input | 1 | Upper strap pin, synchronised |
| sda_i | input | 1 | Bus data line, synchronised |
| scl_i | input | 1 | Bus clock line, synchronised |
| start_i | input | 1 | One-cycle START (or repeated START) strobe |
| stop_i | input | 1 | One-cycle STOP strobe |
| slave_addr_o | output | 7 | Resolved slave address |
| port_dflt_o | output | 8 | Default output byte from reset |
| pullup_en_o | output | 8 | Pullup enables from reset |

## Verification
Two events can fall in the same cycle: the STOP that commits a strap result, and the final sample taken on that same cycle. A strap forced to disagree with the clock line for a single low cycle must come out as a constant level rather than as clock-tied. A strap that mirrors both lines, with the lines held equal from START to STOP, must resolve by the clock-first priority. Each case is judged by the address seen in the cycle after the STOP strobe, against a value computed from the encoding tables. The same check is made after a repeated START that follows a corrupted first segment.

// File: rtl/addr_strap_pkg.sv
package addr_strap_pkg;

    localparam int          ADDR_W      = 7;
    localparam int          PORT_W      = 8;
    localparam int          NUM_STRAPS  = 2;
    localparam int          NIBBLE_W    = PORT_W / NUM_STRAPS;
    localparam logic [2:0]  ADDR_PREFIX = 3'b110;

    typedef enum logic [1:0] {
        CONN_GND = 2'd0,
        CONN_VDD = 2'd1,
        CONN_SCL = 2'd2,
        CONN_SDA = 2'd3
    } conn_e;

    // upper strap -> address bits 3:2
    function automatic logic [1:0] upper_bits(conn_e c);
        case (c)
            CONN_SCL: upper_bits = 2'b00;
            CONN_SDA: upper_bits = 2'b01;
            CONN_GND: upper_bits = 2'b10;
            default:  upper_bits = 2'b11;
        endcase
    endfunction

    // lower strap -> address bits 1:0
    function automatic logic [1:0] lower_bits(conn_e c);
        case (c)
            CONN_GND: lower_bits = 2'b00;
            CONN_VDD: lower_bits = 2'b01;
            CONN_SCL: lower_bits = 2'b10;
            default:  lower_bits = 2'b11;
        endcase
    endfunction

    function automatic conn_e level_conn(logic lvl);
        level_conn = lvl ? CONN_VDD : CONN_GND;
    endfunction

    function automatic logic nibble_on(conn_e c);
        nibble_on = (c != CONN_GND);
    endfunction

endpackage

// File: rtl/strap_window.sv
module strap_window (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic stop_i,
    output logic open_o
);
    always_ff @(posedge clk) begin
        if (rst)          open_o <= 1'b0;
        else if (start_i) open_o <= 1'b1;
        else if (stop_i)  open_o <= 1'b0;
    end

    p_window_opens_r5: assert property (@(posedge clk) disable iff (rst)
        start_i |=> open_o);
    p_window_closes_r4: assert property (@(posedge clk) disable iff (rst)
        (stop_i && !start_i) |=> !open_o);
endmodule

// File: rtl/strap_pin_classifier.sv
module strap_pin_classifier
    import addr_strap_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  pin_i,
    input  logic  sda_i,
    input  logic  scl_i,
    input  logic  start_i,
    input  logic  stop_i,
    input  logic  open_i,
    output conn_e conn_o
);
    logic follow_scl, follow_sda;
    logic low_scl, low_sda;

    logic eq_scl, eq_sda;
    logic fin_scl, fin_sda, fin_low_scl, fin_low_sda;
    logic commit;
    conn_e verdict;

    assign eq_scl = (pin_i == scl_i);
    assign eq_sda = (pin_i == sda_i);

    // view including the sample of the current cycle
    assign fin_scl     = follow_scl & eq_scl;
    assign fin_sda     = follow_sda & eq_sda;
    assign fin_low_scl = low_scl | ~scl_i;
    assign fin_low_sda = low_sda | ~sda_i;
    assign commit      = stop_i & open_i & ~start_i;

    always_comb begin
        if (fin_scl && fin_low_scl)      verdict = CONN_SCL;
        else if (fin_sda && fin_low_sda) verdict = CONN_SDA;
        else                             verdict = level_conn(pin_i);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            conn_o     <= level_conn(pin_i);
            follow_scl <= 1'b0;
            follow_sda <= 1'b0;
            low_scl    <= 1'b0;
            low_sda    <= 1'b0;
        end else begin
            if (start_i) begin
                follow_scl <= eq_scl;
                follow_sda <= eq_sda;
                low_scl    <= ~scl_i;
                low_sda    <= ~sda_i;
            end else if (open_i) begin
                follow_scl <= fin_scl;
                follow_sda <= fin_sda;
                low_scl    <= fin_low_scl;
                low_sda    <= fin_low_sda;
            end
            if (commit && (fin_low_scl || fin_low_sda))
                conn_o <= verdict;
        end
    end

    p_quiet_keeps_r7: assert property (@(posedge clk) disable iff (rst)
        (commit && !low_scl && !low_sda && scl_i && sda_i) |=> $stable(conn_o));
endmodule

// File: rtl/addr_strap_decoder.sv
module addr_strap_decoder
    import addr_strap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ad0_i,
    input  logic              ad2_i,
    input  logic              sda_i,
    input  logic              scl_i,
    input  logic              start_i,
    input  logic              stop_i,
    output logic [ADDR_W-1:0] slave_addr_o,
    output logic [PORT_W-1:0] port_dflt_o,
    output logic [PORT_W-1:0] pullup_en_o
);
    logic  xfer_open;
    logic  strap [NUM_STRAPS];
    conn_e conn  [NUM_STRAPS];

    assign strap[0] = ad0_i;
    assign strap[1] = ad2_i;

    strap_window u_window (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .stop_i  (stop_i),
        .open_o  (xfer_open)
    );

    for (genvar g = 0; g < NUM_STRAPS; g++) begin : g_strap
        strap_pin_classifier u_cls (
            .clk     (clk),
            .rst     (rst),
            .pin_i   (strap[g]),
            .sda_i   (sda_i),
            .scl_i   (scl_i),
            .start_i (start_i),
            .stop_i  (stop_i),
            .open_i  (xfer_open),
            .conn_o  (conn[g])
        );
    end

    assign slave_addr_o = {ADDR_PREFIX, upper_bits(conn[1]), lower_bits(conn[0])};

    // power-up defaults: one nibble per strap, taken from reset classification
    for (genvar n = 0; n < NUM_STRAPS; n++) begin : g_nibble
        always_ff @(posedge clk) begin
            if (rst) begin
                port_dflt_o[n*NIBBLE_W +: NIBBLE_W] <= {NIBBLE_W{nibble_on(level_conn(strap[n]))}};
                pullup_en_o[n*NIBBLE_W +: NIBBLE_W] <= {NIBBLE_W{nibble_on(level_conn(strap[n]))}};
            end
        end
    end

    p_addr_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !stop_i |=> $stable(slave_addr_o));
    p_dflt_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ($stable(port_dflt_o) && $stable(pullup_en_o)));
endmodule

// File: tb/addr_strap_decoder_tb.sv
module addr_strap_decoder_tb;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst = 1'b1;
    logic       sda = 1'b1, scl = 1'b1, st = 1'b0, sp = 1'b0;
    logic [1:0] m0 = 2'd2, m2 = 2'd0;   // 0 gnd, 1 supply, 2 clock-tied, 3 data-tied
    logic       frc0 = 1'b0, frc0_val = 1'b0;
    logic       ad0, ad2;
    logic [6:0] addr;
    logic [7:0] dflt, pull;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    function automatic logic pin_of(logic [1:0] m, logic d, logic c);
        case (m)
            2'd0:    return 1'b0;
            2'd1:    return 1'b1;
            2'd2:    return c;
            default: return d;
        endcase
    endfunction

    always_comb begin
        ad0 = frc0 ? frc0_val : pin_of(m0, sda, scl);
        ad2 = pin_of(m2, sda, scl);
    end

    addr_strap_decoder u_dut (
        .clk          (clk),
        .rst          (rst),
        .ad0_i        (ad0),
        .ad2_i        (ad2),
        .sda_i        (sda),
        .scl_i        (scl),
        .start_i      (st),
        .stop_i       (sp),
        .slave_addr_o (addr),
        .port_dflt_o  (dflt),
        .pullup_en_o  (pull)
    );

    // {upper mode, lower mode, expected address}
    localparam logic [10:0] VEC [16] = '{
        {2'd0, 2'd0, 7'h68}, {2'd0, 2'd1, 7'h69}, {2'd0, 2'd2, 7'h6A}, {2'd0, 2'd3, 7'h6B},
        {2'd1, 2'd0, 7'h6C}, {2'd1, 2'd1, 7'h6D}, {2'd1, 2'd2, 7'h6E}, {2'd1, 2'd3, 7'h6F},
        {2'd2, 2'd0, 7'h60}, {2'd2, 2'd1, 7'h61}, {2'd2, 2'd2, 7'h62}, {2'd2, 2'd3, 7'h63},
        {2'd3, 2'd0, 7'h64}, {2'd3, 2'd1, 7'h65}, {2'd3, 2'd2, 7'h66}, {2'd3, 2'd3, 7'h67}
    };

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    task automatic drive(logic c, logic d, logic s_start, logic s_stop);
        scl = c; sda = d; st = s_start; sp = s_stop;
        @(negedge clk);
        st = 1'b0; sp = 1'b0;
    endtask

    task automatic send_byte(logic [7:0] b, int glitch_bit);
        for (int i = 7; i >= 0; i--) begin
            drive(1'b0, sda, 1'b0, 1'b0);
            if (i == glitch_bit) begin frc0 = 1'b1; frc0_val = 1'b1; end
            drive(1'b0, b[i], 1'b0, 1'b0);
            frc0 = 1'b0;
            drive(1'b1, b[i], 1'b0, 1'b0);
        end
        drive(1'b0, sda, 1'b0, 1'b0);
    endtask

    task automatic xfer(logic [7:0] b, int glitch_bit);
        drive(1'b1, 1'b0, 1'b1, 1'b0);
        send_byte(b, glitch_bit);
        drive(1'b0, 1'b0, 1'b0, 1'b0);
        drive(1'b1, 1'b0, 1'b0, 1'b0);
        drive(1'b1, 1'b1, 1'b0, 1'b1);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        // R8: clock-tied lower strap reads high at reset -> supply; upper ground
        check("R8 reset address", {1'b0, addr}, 8'h69);
        check("R9 reset default byte", dflt, 8'h0F);
        check("R9 reset pullup mask", pull, 8'h0F);

        // R1 R2 R3 R5: every wiring combination
        for (int v = 0; v < 16; v++) begin
            m2 = VEC[v][10:9];
            m0 = VEC[v][8:7];
            @(negedge clk);
            xfer(8'hA5, -1);
            check($sformatf("R1/R2/R3/R5 vector %0d", v), {1'b0, addr}, {1'b0, VEC[v][6:0]});
        end
        check("R9 defaults held after traffic", dflt, 8'h0F);
        check("R9 pullups held after traffic", pull, 8'h0F);

        // R4: stray stop outside a transmission
        m2 = 2'd0; m0 = 2'd0;
        drive(1'b1, 1'b1, 1'b0, 1'b1);
        drive(1'b1, 1'b1, 1'b0, 1'b0);
        check("R4 idle stop ignored", {1'b0, addr}, 8'h67);

        // R4: no change mid-transmission, commit at stop
        drive(1'b1, 1'b0, 1'b1, 1'b0);
        send_byte(8'h3C, -1);
        check("R4 mid-transmission hold", {1'b0, addr}, 8'h67);
        drive(1'b1, 1'b0, 1'b0, 1'b0);
        drive(1'b1, 1'b1, 1'b0, 1'b1);
        check("R4 commit at stop", {1'b0, addr}, 8'h68);

        // R6: lower strap follows clock but mismatches once -> constant high
        m2 = 2'd0; m0 = 2'd2;
        xfer(8'h96, 4);
        check("R6 single mismatch gives level", {1'b0, addr}, 8'h69);

        // R7: no low on either line keeps previous
        m2 = 2'd1; m0 = 2'd1;
        drive(1'b1, 1'b1, 1'b1, 1'b0);
        repeat (3) drive(1'b1, 1'b1, 1'b0, 1'b0);
        drive(1'b1, 1'b1, 1'b0, 1'b1);
        check("R7 lowless transmission keeps", {1'b0, addr}, 8'h69);

        // R10: lines mirror each other, straps data-tied -> clock wins
        m2 = 2'd3; m0 = 2'd3;
        drive(1'b1, 1'b1, 1'b1, 1'b0);
        for (int k = 0; k < 4; k++) begin
            drive(1'b0, 1'b0, 1'b0, 1'b0);
            drive(1'b1, 1'b1, 1'b0, 1'b0);
        end
        drive(1'b1, 1'b1, 1'b0, 1'b1);
        check("R10 clock priority", {1'b0, addr}, 8'h62);

        // R11: corrupted first segment, repeated start, clean second segment
        m2 = 2'd0; m0 = 2'd2;
        drive(1'b1, 1'b0, 1'b1, 1'b0);
        send_byte(8'hF0, 6);
        drive(1'b0, 1'b1, 1'b0, 1'b0);
        drive(1'b1, 1'b1, 1'b0, 1'b0);
        drive(1'b1, 1'b0, 1'b1, 1'b0);
        send_byte(8'h5A, -1);
        drive(1'b1, 1'b0, 1'b0, 1'b0);
        drive(1'b1, 1'b1, 1'b0, 1'b1);
        check("R11 repeated start restarts", {1'b0, addr}, 8'h6A);

        // R8 R9: second reset, upper supply, lower ground
        m2 = 2'd1; m0 = 2'd0;
        do_reset();
        check("R8 second reset address", {1'b0, addr}, 8'h6C);
        check("R9 second reset defaults", dflt, 8'hF0);
        check("R9 second reset pullups", pull, 8'hF0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule